// File: doc/BRIEF.md
# Transceiver Control Register with Edge-Triggered Commands

This block is an 11-bit read/write control register for the baseband controller of a frequency-hopping radio. A simple processor bus writes it in one cycle and can read it back at any time. Most fields are plain levels that drive the rest of the controller: transmit enable, hop-pulse enable, the sync-search word select, the sync-search mode and the transceiver multiplex mode. The multiplex mode is also decoded into a bit-inversion enable and a coprocessor-access enable.

Three bits are commands. They act on the change between the stored value and the newly written value, not on the value alone. Two of them clear sticky status flags that this block holds. A write that takes a clear bit from 1 to 0 clears its flag. The third bit is a sleep request. It fires when it goes from 0 to 1 while sleep is enabled.

The block also holds the sleep/wake state. An external wake level brings the core out of sleep. When that level drops, the core goes straight back to sleep unless software has already cleared the sleep-enable bit. Every command bit reads back as the value last written to it.

Top module: `xcvr_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` is 0, every enable and decoded output is 0, both flags are 0 and `asleep` is 0.
- R2: A cycle with `wr_en` high stores all 11 bits of `wr_data`, and `rd_data` shows them from the next cycle. Command bits read back the last written value, not the flag or sleep state.
- R3: The plain fields appear on their outputs in the cycle after the write. The fields are `tx_enable` = bit 10, `search_word` = bit 9, `search_mode` = bits 8:7 and `hop_enable` = bit 6.
- R4: `mux_mode` is bits 2:1. `bit_invert` is 1 for codes 01 and 11. `coproc_access` is 1 only for code 11. Codes 00 and the reserved code 10 enable neither.
- R5: A one-cycle `sync_acq_set` pulse sets `sync_acq_flag`, and the flag holds until cleared. It clears only when a write takes bit 5 from a stored 1 to a written 0. Writing 0 over a stored 0 leaves it set.
- R6: `frame_start_flag` behaves in the same way, with `frame_start_set` and bit 4.
- R7: When a set pulse and a clearing write land in the same cycle, the flag ends up set.
- R8: A write that takes bit 0 from a stored 0 to a written 1 makes `asleep` 1 in the next cycle, but only if bit 3 (sleep enable) of that same write is 1. With bit 3 at 0 the request is ignored.
- R9: While asleep, a high `wake_in` makes `asleep` 0 in the next cycle.
- R10: After a wake-up, the sleep-enable value decides what happens when `wake_in` falls. If it is 1, `asleep` returns to 1 in the next cycle. If it is 0, the core stays awake. When a write occurs in that cycle, the sleep-enable value used is the one being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 11 | Write data |
| rd_data | output | 11 | Stored register value |
| sync_acq_set | input | 1 | Pulse that sets the sync-acquired flag |
| frame_start_set | input | 1 | Pulse that sets the frame-start flag |
| wake_in | input | 1 | External wake level |
| sync_acq_flag | output | 1 | Sticky sync-acquired flag |
| frame_start_flag | output | 1 | Sticky frame-start flag |
| tx_enable | output | 1 | Global transmit enable |
| hop_enable | output | 1 | Hop-pulse enable |
| search_word | output | 1 | Search word select |
| search_mode | output | 2 | Search mode (none, window, full) |
| mux_mode | output | 2 | Raw multiplex mode |
| bit_invert | output | 1 | Bit inversion enable |
| coproc_access | output | 1 | Coprocessor access enable |
| asleep | output | 1 | Core is in sleep |

## Verification
The assertions assume that `wr_data` is a known value whenever `wr_en` is high. They also assume the set pulses and `wake_in` change only between clock edges, so each change is sampled as a clean level.

The bench drives every input on the falling edge, one value at a time. Writes last exactly one cycle, and set pulses last exactly one cycle. `wake_in` is held at 0 through the full sweep of all 2048 write values, so the expected sleep state there depends only on the write sequence. Wake behaviour is tested separately from a fresh reset.

// File: rtl/xcvr_ctrl_reg.sv
module xcvr_ctrl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [10:0] wr_data,
  output logic [10:0] rd_data,
  input  logic        sync_acq_set,
  input  logic        frame_start_set,
  input  logic        wake_in,
  output logic        sync_acq_flag,
  output logic        frame_start_flag,
  output logic        tx_enable,
  output logic        hop_enable,
  output logic        search_word,
  output logic [1:0]  search_mode,
  output logic [1:0]  mux_mode,
  output logic        bit_invert,
  output logic        coproc_access,
  output logic        asleep
);

  localparam int B_TX    = 10;
  localparam int B_WORD  = 9;
  localparam int B_HOP   = 6;
  localparam int B_SCLR  = 5;
  localparam int B_FCLR  = 4;
  localparam int B_SLPEN = 3;
  localparam int B_GO    = 0;

  typedef enum logic [1:0] {ST_AWAKE, ST_ASLEEP, ST_WOKEN} slp_t;

  logic [10:0] ctl_q;
  slp_t        st_q, st_d;
  logic        sclr_hit, fclr_hit, go_hit, slp_en_eff;

  assign sclr_hit   = wr_en &  ctl_q[B_SCLR] & ~wr_data[B_SCLR];
  assign fclr_hit   = wr_en &  ctl_q[B_FCLR] & ~wr_data[B_FCLR];
  assign go_hit     = wr_en & ~ctl_q[B_GO] & wr_data[B_GO] & wr_data[B_SLPEN];
  assign slp_en_eff = wr_en ? wr_data[B_SLPEN] : ctl_q[B_SLPEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_acq_flag    <= 1'b0;
      frame_start_flag <= 1'b0;
    end else begin
      if (sync_acq_set)         sync_acq_flag <= 1'b1;
      else if (sclr_hit)        sync_acq_flag <= 1'b0;
      if (frame_start_set)      frame_start_flag <= 1'b1;
      else if (fclr_hit)        frame_start_flag <= 1'b0;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_AWAKE:  if (go_hit) st_d = ST_ASLEEP;
      ST_ASLEEP: if (wake_in) st_d = ST_WOKEN;
      ST_WOKEN: begin
        if (go_hit)               st_d = ST_ASLEEP;
        else if (!slp_en_eff)     st_d = ST_AWAKE;
        else if (!wake_in)        st_d = ST_ASLEEP;
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_AWAKE;
    else        st_q <= st_d;
  end

  assign rd_data       = ctl_q;
  assign tx_enable     = ctl_q[B_TX];
  assign search_word   = ctl_q[B_WORD];
  assign search_mode   = ctl_q[8:7];
  assign hop_enable    = ctl_q[B_HOP];
  assign mux_mode      = ctl_q[2:1];
  assign bit_invert    = ctl_q[1];
  assign coproc_access = ctl_q[2] & ctl_q[1];
  assign asleep        = (st_q == ST_ASLEEP);

endmodule

module xcvr_ctrl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [10:0] wr_data,
  input logic [10:0] rd_data,
  input logic        sync_acq_set,
  input logic        frame_start_set,
  input logic        wake_in,
  input logic        sync_acq_flag,
  input logic        frame_start_flag,
  input logic        tx_enable,
  input logic        hop_enable,
  input logic        coproc_access,
  input logic        bit_invert,
  input logic        asleep
);

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R3
  enables_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tx_enable == $past(wr_data[10])) && (hop_enable == $past(wr_data[6])));

  // R4
  coproc_implies_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coproc_access |-> bit_invert);

  // R5
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[5] && !wr_data[5] && !sync_acq_set) |=> !sync_acq_flag);

  // R6
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[4] && !wr_data[4] && !frame_start_set) |=> !frame_start_flag);

  // R7
  sync_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_acq_set |=> sync_acq_flag);

  // R7
  frame_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_set |=> frame_start_flag);

  // R8
  go_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[0] && wr_data[0] && wr_data[3] && !asleep) |=> asleep);

  // R9
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake_in) |=> !asleep);

  // R10
  no_sleep_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3] && !asleep) |=> !asleep);

endmodule

bind xcvr_ctrl_reg xcvr_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .sync_acq_set(sync_acq_set), .frame_start_set(frame_start_set), .wake_in(wake_in),
  .sync_acq_flag(sync_acq_flag), .frame_start_flag(frame_start_flag),
  .tx_enable(tx_enable), .hop_enable(hop_enable), .coproc_access(coproc_access),
  .bit_invert(bit_invert), .asleep(asleep)
);

// File: tb/xcvr_ctrl_reg_bench.sv
module xcvr_ctrl_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_data = '0;
  logic        sync_acq_set = 1'b0;
  logic        frame_start_set = 1'b0;
  logic        wake_in = 1'b0;
  logic [10:0] rd_data;
  logic        sync_acq_flag, frame_start_flag, tx_enable, hop_enable, search_word;
  logic [1:0]  search_mode, mux_mode;
  logic        bit_invert, coproc_access, asleep;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  xcvr_ctrl_reg u_xcvr_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sync_acq_set(sync_acq_set), .frame_start_set(frame_start_set), .wake_in(wake_in),
    .sync_acq_flag(sync_acq_flag), .frame_start_flag(frame_start_flag),
    .tx_enable(tx_enable), .hop_enable(hop_enable), .search_word(search_word),
    .search_mode(search_mode), .mux_mode(mux_mode), .bit_invert(bit_invert),
    .coproc_access(coproc_access), .asleep(asleep)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] v, input logic sset, input logic fset);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; sync_acq_set = sset; frame_start_set = fset;
    @(negedge clk);
    wr_en = 1'b0; sync_acq_set = 1'b0; frame_start_set = 1'b0;
  endtask

  task automatic pulse(input logic sset, input logic fset);
    @(negedge clk);
    sync_acq_set = sset; frame_start_set = fset;
    @(negedge clk);
    sync_acq_set = 1'b0; frame_start_set = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [10:0] prev;
    logic        exp_slp;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 rd_data", rd_data, 0);
    check("R1 outputs", {tx_enable, hop_enable, search_word, search_mode, mux_mode, bit_invert, coproc_access}, 0);
    check("R1 flags", {sync_acq_flag, frame_start_flag}, 0);
    check("R1 asleep", asleep, 0);

    prev = '0; exp_slp = 1'b0;
    for (int v = 0; v < 2048; v++) begin
      logic [10:0] d;
      d = v[10:0];
      wr(d, 1'b0, 1'b0);
      if (!prev[0] && d[0] && d[3]) exp_slp = 1'b1;
      check("R2 readback", rd_data, d);
      check("R3 tx_enable", tx_enable, d[10]);
      check("R3 search_word", search_word, d[9]);
      check("R3 search_mode", search_mode, d[8:7]);
      check("R3 hop_enable", hop_enable, d[6]);
      check("R4 mux_mode", mux_mode, d[2:1]);
      check("R4 bit_invert", bit_invert, d[2:1] == 2'b01 || d[2:1] == 2'b11);
      check("R4 coproc_access", coproc_access, d[2:1] == 2'b11);
      check("R8 asleep sweep", asleep, exp_slp);
      prev = d;
    end

    do_reset();
    // R5 sticky set and transition clear
    pulse(1'b1, 1'b0);
    check("R5 set", sync_acq_flag, 1);
    check("R6 untouched", frame_start_flag, 0);
    wr(11'h020, 1'b0, 1'b0);
    check("R5 write 1 keeps", sync_acq_flag, 1);
    wr(11'h000, 1'b0, 1'b0);
    check("R5 1to0 clears", sync_acq_flag, 0);
    pulse(1'b1, 1'b0);
    wr(11'h000, 1'b0, 1'b0);
    check("R5 0to0 no clear", sync_acq_flag, 1);
    check("R2 cmd readback", rd_data, 0);
    // R6
    pulse(1'b0, 1'b1);
    check("R6 set", frame_start_flag, 1);
    wr(11'h010, 1'b0, 1'b0);
    check("R6 write 1 keeps", frame_start_flag, 1);
    check("R2 cmd bit reads written", rd_data, 11'h010);
    wr(11'h000, 1'b0, 1'b0);
    check("R6 1to0 clears", frame_start_flag, 0);
    check("R5 other flag kept", sync_acq_flag, 1);
    // R7
    wr(11'h030, 1'b0, 1'b0);
    wr(11'h000, 1'b1, 1'b1);
    check("R7 sync set wins", sync_acq_flag, 1);
    check("R7 frame set wins", frame_start_flag, 1);

    do_reset();
    // R8
    wr(11'h001, 1'b0, 1'b0);
    check("R8 disabled ignored", asleep, 0);
    wr(11'h000, 1'b0, 1'b0);
    wr(11'h009, 1'b0, 1'b0);
    check("R8 enabled sleeps", asleep, 1);
    // R9
    @(negedge clk); wake_in = 1'b1;
    @(negedge clk);
    check("R9 wake", asleep, 0);
    @(negedge clk);
    check("R9 stays awake while wake high", asleep, 0);
    // R10
    wake_in = 1'b0;
    @(negedge clk);
    check("R10 re-sleep", asleep, 1);
    wake_in = 1'b1;
    @(negedge clk);
    check("R9 wake again", asleep, 0);
    wr(11'h000, 1'b0, 1'b0);
    @(negedge clk); wake_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 enable cleared stays awake", asleep, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule